// File: doc/BRIEF.md
# NAND Command and Address Front End

This block is the input stage of a small NAND flash device model. On every cycle where the bus write strobe `bus_wr` is high, it looks at the 8-bit I/O bus. Three things decide what the byte means: the command latch enable, the address latch enable and the active-low chip enable. A command byte is decoded and may be folded into a related command. An address byte goes into an address register, least significant byte first. The block decides when the latched command has enough information to start. At that point it issues a one-cycle start pulse carrying a command code, a full address and a column offset for the rest of the device.

The page organisation is fixed by parameters: small-page or large-page, and, for large-page, whether the device is above 1 Gbit. These choose how many address cycles a read or program needs and how far an erase address is shifted. A three-state machine tracks the command phase:
- `ST_IDLE`: no operation pending.
- `ST_COLLECT`: a command is waiting for address cycles.
- `ST_ISSUED`: the operation has started.

The transitions are:
- IDLE/ISSUED to COLLECT on a command that needs an address (read, program load, read ID, copy-back load).
- Any state to ISSUED on an immediate command.
- COLLECT to ISSUED when the address count reaches the trigger count.
- Any state to IDLE on reset (0xFF) or on an unrecognised opcode.

Top module: `nand_cmd_front`

## Requirements
- R1: After `rst_n` is asserted, `op_start` is 0 and `op_code`, `op_addr` and `op_col` are 0. The internal state is: current command read (0x00), offset 0, address 0, cycle count 0, state IDLE.
- R2: Opcode 0x01 becomes read 0x00 with column offset 0x100. Opcode 0x50 becomes read 0x00 with offset equal to `PAGE_BYTES`. Opcode 0x00 sets the offset to 0. The offset is reported on `op_col` when the read starts and is then cleared. Every other start reports `op_col` = 0.
- R3: The immediate opcodes 0x70, 0x10, 0x60, 0xD0, 0xE0, 0x35 and 0xFF cause `op_start` in the cycle after the strobe. The pulse has `op_code` equal to the opcode and `op_addr` equal to the accumulated address (R7 gives the 0xD0 exception). Opcode 0xFF also clears address, cycle count, offset and current command.
- R4: Address byte k (counting from 0 since the last count reset) fills bits [8k+7:8k]. Bytes beyond `ADDR_CYCLES` are dropped.
- R5: Read ID (0x90) starts on its first address byte, with `op_addr` including that byte.
- R6: Read (0x00) and program load (0x80) start on the address byte that brings the count to 3 in small-page mode. The count is 4 in large-page mode with `BIG_DEVICE`=0 and 5 with `BIG_DEVICE`=1.
- R7: On 0xD0, `op_addr` is the address truncated to the bytes received, shifted left by 8 in small-page mode or by 16 in large-page mode.
- R8: In large-page mode, 0x30 received while the current command is read produces no pulse and changes no state.
- R9: In large-page mode, 0x05 clears the column bytes of the address (the low 2 bytes) and resets the count, but keeps the current command. Later column bytes followed by 0xE0 start with the new column and the old row.
- R10: Every accepted command other than 0xE0 and the swallowed 0x30 resets the cycle count.
- R11: Command bytes with `ce_n` high are ignored. Address bytes are accepted whatever the level of `ce_n`.
- R12: A byte with both latch enables high is discarded, and no start follows it.
- R13: `op_start` lasts one cycle per triggering byte. Further address bytes in `ST_ISSUED` do not start it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte on `io_in` is valid this cycle |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io_in | input | 8 | I/O bus byte |
| op_start | output | 1 | One-cycle operation start |
| op_code | output | 8 | Command code of the started operation |
| op_addr | output | ADDR_CYCLES*8+16 (56) | Operation address |
| op_col | output | $clog2(PAGE_BYTES)+1 (12) | Column offset for reads |

## Verification
Two paths can be active on the same strobe: command decoding and address accumulation. This happens when the command and address latch enables are high together, or when an address byte arrives while chip enable is high and a command there would be blocked.

The bench provokes both with directed strokes and with random strobes that raise both enables. It then judges them by three observations:
- No start pulse follows a byte with both enables high.
- The address seen at the next start shows whether the discarded byte entered the register.
- An address byte sent with chip enable high does count toward the trigger.

Three instances run side by side in the three page modes on one shared bus. This shows the mode-dependent trigger count and erase shift on the same stimulus.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam logic [7:0] OPC_READ       = 8'h00;
    localparam logic [7:0] OPC_READ_HI    = 8'h01;
    localparam logic [7:0] OPC_READ_SPARE = 8'h50;
    localparam logic [7:0] OPC_LP_CONFIRM = 8'h30;
    localparam logic [7:0] OPC_NOSEQ_GO   = 8'h35;
    localparam logic [7:0] OPC_COL_JUMP   = 8'h05;
    localparam logic [7:0] OPC_COL_GO     = 8'hE0;
    localparam logic [7:0] OPC_ID         = 8'h90;
    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_PROG_LOAD  = 8'h80;
    localparam logic [7:0] OPC_PROG_GO    = 8'h10;
    localparam logic [7:0] OPC_ERASE_ARM  = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OPC_STATUS     = 8'h70;
    localparam logic [7:0] OPC_COPY_LOAD  = 8'h85;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ISSUED
    } fsm_e;

    function automatic logic is_immediate(input logic [7:0] c);
        return (c == OPC_STATUS)   || (c == OPC_PROG_GO)  ||
               (c == OPC_ERASE_ARM)|| (c == OPC_ERASE_GO) ||
               (c == OPC_COL_GO)   || (c == OPC_NOSEQ_GO) ||
               (c == OPC_RESET);
    endfunction

    function automatic logic needs_address(input logic [7:0] c);
        return (c == OPC_READ) || (c == OPC_PROG_LOAD) ||
               (c == OPC_ID)   || (c == OPC_COPY_LOAD);
    endfunction

endpackage

// File: rtl/nfc_opcode_map.sv
module nfc_opcode_map
    import nfc_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b1,
    parameter int PAGE_BYTES = 2048,
    parameter int COL_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic [7:0]       raw,
    input  logic [7:0]       cur_cmd,
    output logic             swallow,
    output logic             col_jump,
    output logic [7:0]       eff_code,
    output logic             set_off,
    output logic [COL_W-1:0] off_val,
    output logic             immediate,
    output logic             waits_addr,
    output logic             keep_count
);

    localparam logic [COL_W-1:0] OFF_HALF  = COL_W'(256);
    localparam logic [COL_W-1:0] OFF_SPARE = COL_W'(PAGE_BYTES);

    always_comb begin
        swallow  = 1'b0;
        col_jump = 1'b0;
        eff_code = raw;
        set_off  = 1'b0;
        off_val  = '0;
        if (LARGE_PAGE) begin
            swallow  = (raw == OPC_LP_CONFIRM) && (cur_cmd == OPC_READ);
            col_jump = (raw == OPC_COL_JUMP);
        end
        unique case (raw)
            OPC_READ:       begin set_off = 1'b1; off_val = '0; end
            OPC_READ_HI:    begin set_off = 1'b1; off_val = OFF_HALF;  eff_code = OPC_READ; end
            OPC_READ_SPARE: begin set_off = 1'b1; off_val = OFF_SPARE; eff_code = OPC_READ; end
            default:        ;
        endcase
        immediate  = is_immediate(eff_code);
        waits_addr = needs_address(eff_code);
        keep_count = (eff_code == OPC_COL_GO);
    end

endmodule

// File: rtl/nfc_addr_acc.sv
module nfc_addr_acc #(
    parameter int ADDR_CYCLES = 5,
    parameter int COL_CYC     = 2,
    parameter int ACC_W       = ADDR_CYCLES * 8,
    parameter int CNT_W       = $clog2(ADDR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             clr_col,
    input  logic             clr_cnt,
    input  logic             take,
    input  logic [7:0]       byte_in,
    output logic [ACC_W-1:0] addr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [ACC_W-1:0] addr_nx,
    output logic [CNT_W-1:0] cnt_nx
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ADDR_CYCLES);
    localparam logic [ACC_W-1:0] ROW_MASK = ~((ACC_W'(1) << (COL_CYC * 8)) - ACC_W'(1));

    always_comb begin
        addr_nx = addr_q;
        cnt_nx  = cnt_q;
        if (cnt_q < CNT_MAX) begin
            addr_nx[cnt_q*8 +: 8] = byte_in;
            cnt_nx = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (clr_col) begin
            addr_q <= addr_q & ROW_MASK;
            cnt_q  <= '0;
        end else if (clr_cnt) begin
            cnt_q  <= '0;
        end else if (take) begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_nx;
        end
    end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nfc_pkg::*;
#(
    parameter bit LARGE_PAGE  = 1'b1,
    parameter bit BIG_DEVICE  = 1'b0,
    parameter int PAGE_BYTES  = 2048,
    parameter int ADDR_CYCLES = 5,
    parameter int ADDR_W      = ADDR_CYCLES * 8 + 16,
    parameter int COL_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic [7:0]        io_in,
    output logic              op_start,
    output logic [7:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [COL_W-1:0]  op_col
);

    localparam int ACC_W    = ADDR_CYCLES * 8;
    localparam int CNT_W    = $clog2(ADDR_CYCLES + 1);
    localparam int COL_CYC  = LARGE_PAGE ? 2 : 1;
    localparam int ERASE_SH = LARGE_PAGE ? 16 : 8;
    localparam int TRIG_N   = LARGE_PAGE ? (BIG_DEVICE ? 5 : 4) : 3;
    localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG_N);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    // strobe qualification
    logic wr_cmd, wr_adr;
    assign wr_cmd = bus_wr && cle && !ale && !ce_n;
    assign wr_adr = bus_wr && ale && !cle;

    // current command, offset, state
    logic [7:0]       cmd_q;
    logic [COL_W-1:0] off_q;
    fsm_e             state_q, state_d;

    // opcode decoding
    logic             m_swallow, m_coljump, m_setoff, m_imm, m_wait, m_keep;
    logic [7:0]       m_code;
    logic [COL_W-1:0] m_offval;

    nfc_opcode_map #(
        .LARGE_PAGE (LARGE_PAGE),
        .PAGE_BYTES (PAGE_BYTES),
        .COL_W      (COL_W)
    ) u_map (
        .raw        (io_in),
        .cur_cmd    (cmd_q),
        .swallow    (m_swallow),
        .col_jump   (m_coljump),
        .eff_code   (m_code),
        .set_off    (m_setoff),
        .off_val    (m_offval),
        .immediate  (m_imm),
        .waits_addr (m_wait),
        .keep_count (m_keep)
    );

    logic cmd_take, is_reset;
    assign cmd_take = wr_cmd && !m_swallow && !m_coljump;
    assign is_reset = cmd_take && (m_code == OPC_RESET);

    // address accumulation
    logic [ACC_W-1:0] addr_q, addr_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    nfc_addr_acc #(
        .ADDR_CYCLES (ADDR_CYCLES),
        .COL_CYC     (COL_CYC),
        .ACC_W       (ACC_W),
        .CNT_W       (CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (is_reset),
        .clr_col (wr_cmd && m_coljump),
        .clr_cnt (cmd_take && !m_keep),
        .take    (wr_adr),
        .byte_in (io_in),
        .addr_q  (addr_q),
        .cnt_q   (cnt_q),
        .addr_nx (addr_nx),
        .cnt_nx  (cnt_nx)
    );

    // erase address: keep only received bytes, then shift to block position
    logic [ACC_W-1:0]  keep_mask;
    logic [ADDR_W-1:0] erase_addr;

    for (genvar b = 0; b < ADDR_CYCLES; b++) begin : g_lane
        assign keep_mask[b*8 +: 8] = (CNT_W'(b) < cnt_q) ? 8'hFF : 8'h00;
    end

    assign erase_addr = {{(ADDR_W-ACC_W){1'b0}}, addr_q & keep_mask} << ERASE_SH;

    // start conditions
    logic cmd_fire, adr_fire, cnt_grows;
    assign cmd_fire  = cmd_take && m_imm;
    assign cnt_grows = wr_adr && (cnt_nx != cnt_q);
    assign adr_fire  = cnt_grows && (state_q == ST_COLLECT) &&
                       (((cmd_q == OPC_ID) && (cnt_nx == ONE_CNT)) ||
                        (((cmd_q == OPC_READ) || (cmd_q == OPC_PROG_LOAD)) &&
                         (cnt_nx == TRIG_CNT)));

    // next state
    always_comb begin
        state_d = state_q;
        if (cmd_take) begin
            if (is_reset)    state_d = ST_IDLE;
            else if (m_imm)  state_d = ST_ISSUED;
            else if (m_wait) state_d = ST_COLLECT;
            else             state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: state_d = adr_fire ? ST_ISSUED : ST_COLLECT;
                ST_ISSUED:  state_d = ST_ISSUED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state, command and offset registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= OPC_READ;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            if (is_reset) begin
                cmd_q <= OPC_READ;
                off_q <= '0;
            end else if (cmd_take) begin
                cmd_q <= m_code;
                if (m_setoff) off_q <= m_offval;
            end else if (adr_fire && (cmd_q == OPC_READ)) begin
                off_q <= '0;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_code  <= '0;
            op_addr  <= '0;
            op_col   <= '0;
        end else begin
            op_start <= cmd_fire || adr_fire;
            if (cmd_fire) begin
                op_code <= m_code;
                op_addr <= (m_code == OPC_ERASE_GO) ? erase_addr
                                                    : {{(ADDR_W-ACC_W){1'b0}}, addr_q};
                op_col  <= '0;
            end else if (adr_fire) begin
                op_code <= cmd_q;
                op_addr <= {{(ADDR_W-ACC_W){1'b0}}, addr_nx};
                op_col  <= (cmd_q == OPC_READ) ? off_q : '0;
            end
        end
    end

endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic [7:0] io_in,
    input logic       op_start,
    input logic [7:0] op_code
);

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !op_start);

    p_status_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ce_n && cle && !ale && io_in == 8'h70) |=> (op_start && op_code == 8'h70));

    p_ce_blocks_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ce_n && cle && !ale) |=> !op_start);

    p_both_enables_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cle && ale) |=> !op_start);

    p_pulse_needs_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !op_start);

endmodule

bind nand_cmd_front nfc_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .io_in    (io_in),
    .op_start (op_start),
    .op_code  (op_code)
);

// File: tb/tb_nand_cmd_front.sv
module tb_nand_cmd_front;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0] io_in = '0;

    always #5 clk = ~clk;

    logic        st_a [3];
    logic [7:0]  code_a [3];
    logic [55:0] addr_a [3];
    logic [11:0] col_a [3];
    logic [9:0]  col_sp;

    nand_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ce_n(ce_n), .cle(cle), .ale(ale),
        .io_in(io_in), .op_start(st_a[0]), .op_code(code_a[0]), .op_addr(addr_a[0]), .op_col(col_a[0]));

    nand_cmd_front #(.LARGE_PAGE(1'b0), .PAGE_BYTES(512)) dut_sp (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ce_n(ce_n), .cle(cle), .ale(ale),
        .io_in(io_in), .op_start(st_a[1]), .op_code(code_a[1]), .op_addr(addr_a[1]), .op_col(col_sp));

    nand_cmd_front #(.LARGE_PAGE(1'b1), .BIG_DEVICE(1'b1)) dut_lb (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ce_n(ce_n), .cle(cle), .ale(ale),
        .io_in(io_in), .op_start(st_a[2]), .op_code(code_a[2]), .op_addr(addr_a[2]), .op_col(col_a[2]));

    assign col_a[1] = {2'b00, col_sp};

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // reference state per configuration (0 large, 1 small, 2 large big)
    logic [39:0] maddr [3];
    int          mcyc [3];
    int          mst [3];
    logic [7:0]  mcmd [3];
    logic [11:0] moff [3];
    bit          efire [3];
    logic [7:0]  ecode [3];
    logic [55:0] eaddr [3];
    logic [11:0] ecol [3];

    function automatic bit lg(int i);  return i != 1; endfunction
    function automatic int trig(int i); return (i == 1) ? 3 : ((i == 2) ? 5 : 4); endfunction
    function automatic int pbytes(int i); return (i == 1) ? 512 : 2048; endfunction
    function automatic bit imm(logic [7:0] c);
        return c == 8'h70 || c == 8'h10 || c == 8'h60 || c == 8'hD0 ||
               c == 8'hE0 || c == 8'h35 || c == 8'hFF;
    endfunction
    function automatic bit wait_addr(logic [7:0] c);
        return c == 8'h00 || c == 8'h80 || c == 8'h90 || c == 8'h85;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            maddr[i] = '0; mcyc[i] = 0; mst[i] = 0; mcmd[i] = 8'h00; moff[i] = '0;
        end
    endtask

    task automatic model_step(int i, bit ce, bit cl, bit al, logic [7:0] d);
        logic [7:0]  e;
        logic [39:0] keep;
        efire[i] = 1'b0; ecode[i] = '0; eaddr[i] = '0; ecol[i] = '0;
        if (cl && al) return;
        if (cl) begin
            if (ce) return;
            if (lg(i) && d == 8'h30 && mcmd[i] == 8'h00) return;
            if (lg(i) && d == 8'h05) begin
                maddr[i][15:0] = '0; mcyc[i] = 0; return;
            end
            e = d;
            if (d == 8'h00) moff[i] = '0;
            if (d == 8'h01) begin moff[i] = 12'h100; e = 8'h00; end
            if (d == 8'h50) begin moff[i] = 12'(pbytes(i)); e = 8'h00; end
            if (imm(e)) begin
                efire[i] = 1'b1; ecode[i] = e;
                if (e == 8'hD0) begin
                    keep = '0;
                    for (int b = 0; b < mcyc[i]; b++) keep[b*8 +: 8] = 8'hFF;
                    eaddr[i] = {16'h0, maddr[i] & keep} << (lg(i) ? 16 : 8);
                end else eaddr[i] = {16'h0, maddr[i]};
            end
            if (e == 8'hFF) begin
                model_reset_one(i);
            end else begin
                if (e != 8'hE0) mcyc[i] = 0;
                mcmd[i] = e;
                mst[i] = imm(e) ? 2 : (wait_addr(e) ? 1 : 0);
            end
        end else if (al) begin
            if (mcyc[i] < 5) begin
                maddr[i][mcyc[i]*8 +: 8] = d;
                mcyc[i]++;
                if (mst[i] == 1 && ((mcmd[i] == 8'h90 && mcyc[i] == 1) ||
                    ((mcmd[i] == 8'h00 || mcmd[i] == 8'h80) && mcyc[i] == trig(i)))) begin
                    efire[i] = 1'b1; ecode[i] = mcmd[i]; eaddr[i] = {16'h0, maddr[i]};
                    if (mcmd[i] == 8'h00) begin ecol[i] = moff[i]; moff[i] = '0; end
                    mst[i] = 2;
                end
            end
        end
    endtask

    task automatic model_reset_one(int i);
        maddr[i] = '0; mcyc[i] = 0; mst[i] = 0; mcmd[i] = 8'h00; moff[i] = '0;
    endtask

    task automatic wr(bit ce, bit cl, bit al, logic [7:0] d, string tag);
        @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk(st_a[i] == 1'b0, "R13", "pulse width", 64'(st_a[i]), 64'h0);
        ce_n = ce; cle = cl; ale = al; io_in = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cle = 1'b0; ale = 1'b0;
        for (int i = 0; i < 3; i++) begin
            model_step(i, ce, cl, al, d);
            chk(st_a[i] == efire[i], tag, "op_start", 64'(st_a[i]), 64'(efire[i]));
            if (efire[i]) begin
                chk(code_a[i] == ecode[i], tag, "op_code", 64'(code_a[i]), 64'(ecode[i]));
                chk(addr_a[i] == eaddr[i], tag, "op_addr", 64'(addr_a[i]), 64'(eaddr[i]));
                chk(col_a[i] == ecol[i], tag, "op_col", 64'(col_a[i]), 64'(ecol[i]));
            end
        end
    endtask

    task automatic cmd(logic [7:0] d, string tag); wr(1'b0, 1'b1, 1'b0, d, tag); endtask
    task automatic adr(logic [7:0] d, string tag); wr(1'b0, 1'b0, 1'b1, d, tag); endtask

    logic [7:0] ops [16] = '{8'h00, 8'h01, 8'h50, 8'h30, 8'h35, 8'h05, 8'hE0, 8'h90,
                             8'hFF, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70, 8'h85, 8'h42};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int r;
        seed = $urandom(32'h5EED);
        model_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(st_a[i] == 1'b0, "R1", "op_start in reset", 64'(st_a[i]), 64'h0);
            chk(addr_a[i] == '0 && code_a[i] == '0 && col_a[i] == '0, "R1", "outputs in reset",
                64'(addr_a[i]), 64'h0);
        end
        rst_n = 1'b1;

        // R6 / R4: read, five address bytes, trigger count per mode
        cmd(8'h00, "R6");
        adr(8'h11, "R4"); adr(8'h22, "R4"); adr(8'h33, "R6"); adr(8'h44, "R6"); adr(8'h55, "R6");
        adr(8'h66, "R13");            // beyond the count, dropped, no restart
        // R2: read second half and spare
        cmd(8'h01, "R2");
        adr(8'h01, "R2"); adr(8'h02, "R2"); adr(8'h03, "R2"); adr(8'h04, "R2"); adr(8'h05, "R2");
        cmd(8'h50, "R2");
        adr(8'hA0, "R2"); adr(8'hA1, "R2"); adr(8'hA2, "R2"); adr(8'hA3, "R2"); adr(8'hA4, "R2");
        // R8: large-page confirm swallowed after a read
        cmd(8'h30, "R8");
        adr(8'h77, "R8");
        // R9: column jump then random read
        cmd(8'h05, "R9"); adr(8'hC1, "R9"); adr(8'hC2, "R9"); cmd(8'hE0, "R9");
        // R5: read ID
        cmd(8'h90, "R5"); adr(8'h00, "R5"); adr(8'h01, "R13");
        // R7 / R10: erase with three bytes
        cmd(8'h60, "R3"); adr(8'h12, "R7"); adr(8'h34, "R7"); adr(8'h56, "R7"); cmd(8'hD0, "R7");
        // R10: program restarted by a new command part way
        cmd(8'h80, "R10"); adr(8'h01, "R10"); adr(8'h02, "R10");
        cmd(8'h80, "R10"); adr(8'h03, "R10"); adr(8'h04, "R10"); adr(8'h05, "R10");
        adr(8'h06, "R10"); adr(8'h07, "R10");
        cmd(8'h10, "R3");
        // R11: chip enable high blocks commands, not addresses
        wr(1'b1, 1'b1, 1'b0, 8'h70, "R11");
        cmd(8'h00, "R11");
        wr(1'b1, 1'b0, 1'b1, 8'h9A, "R11"); adr(8'h9B, "R11"); adr(8'h9C, "R11");
        adr(8'h9D, "R11"); adr(8'h9E, "R11");
        // R12: both enables high
        cmd(8'h90, "R12");
        wr(1'b0, 1'b1, 1'b1, 8'h70, "R12");
        adr(8'h3C, "R12");
        // R3: status and reset
        cmd(8'h70, "R3"); cmd(8'h35, "R3"); cmd(8'hFF, "R3");
        cmd(8'h10, "R3");

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            r = $urandom_range(0, 99);
            if (r < 30)       cmd(ops[$urandom_range(0, 15)], "R3");
            else if (r < 80)  adr(8'($urandom), "R6");
            else if (r < 86)  wr(1'b1, 1'b1, 1'b0, ops[$urandom_range(0, 15)], "R11");
            else if (r < 91)  wr(1'b0, 1'b1, 1'b1, 8'($urandom), "R12");
            else              wr(1'($urandom), 1'b0, 1'b0, 8'($urandom), "R13");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule